// File: doc/BRIEF.md
# Misaligned Memory Access Sequencer

This block connects a processor load/store port to a byte-addressed memory that is organised as two-byte words. The memory has a single word-wide port and does one read or one write per clock. The processor can ask for a word or a single byte, for a read or a write, at any byte address. The block turns each request into whole-word memory cycles:

- a single plain cycle when the access fits inside one word;
- two reads, whose bytes are merged, for a word that starts at an odd address;
- read-modify-write pairs for byte stores;
- two read-modify-write pairs for a word store at an odd address.

A small combinational steering function works out the byte-lane multiplexer selects for the access. It also flags the one case that the lane network cannot serve alone, a word at an odd address. That flag sends the request to a split sequence. The block returns the aligned read data together with a one-clock completion pulse.

Requests are taken on a valid/ready handshake. The block holds the request internally while it works through the sequence. When the last memory cycle of a sequence is in progress, a new request can be taken in that same cycle, so sequences follow each other with no idle cycle between them. The memory is expected to return read data in the same cycle as the address and to write on the clock edge.

Top module: `ums_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `rsp_done` is 0 and `mem_we` is 0.
- R2: A word read at an even byte address uses one memory read cycle of the word at `req_addr>>1`. It returns that word unchanged, with bits [7:0] holding the byte at the even address.
- R3: A word write at an even byte address uses one memory cycle with `mem_we`=1. That cycle writes the whole of `req_wdata` to word `req_addr>>1`.
- R4: A byte read uses one memory read cycle. It returns the addressed byte in bits [7:0] with the upper byte zero. Lane 0 (bits [7:0]) of a memory word holds the even byte address and lane 1 (bits [15:8]) holds the odd one.
- R5: A byte write takes two memory cycles:
  - first, a read of the containing word;
  - then a write-back of that word with `req_wdata[7:0]` placed in the addressed lane and the other lane unchanged.
- R6: A word read at an odd byte address takes two read cycles. Result bits [7:0] are lane 1 of word `req_addr>>1`. Result bits [15:8] are lane 0 of the next word.
- R7: A word write at an odd byte address takes four cycles, made of two byte read-modify-writes. The first places `req_wdata[7:0]` in lane 1 of word `req_addr>>1`. The second places `req_wdata[15:8]` in lane 0 of the next word. All other bytes are kept.
- R8: The next word after word MEM_WORDS-1 is word 0, for both split reads and split writes.
- R9: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is 0 in every cycle of a sequence except the last.
- R10: `rsp_done` is 1 for exactly one clock, in the cycle after the last memory cycle of each request, in request order. `rsp_rdata` holds the read result in that cycle.
- R11: `mem_we` is 1 only in a write cycle. In a read-modify-write, the write-back goes to the word read in the cycle just before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 2*BYTE_W | Write data; byte data in the low lane |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 2*BYTE_W | Aligned read data, valid with `rsp_done` |
| mem_addr | output | ADDR_W-1 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 2*BYTE_W | Memory write data |
| mem_rdata | input | 2*BYTE_W | Memory read data for `mem_addr`, same cycle |

## Verification
The bench builds the block with 8-bit bytes, a 6-bit byte address and 24 memory words. Because 24 is not a power of two, this setting selects the compare-and-reset variant of the next-word logic instead of plain rollover. It also puts the top word, where the wrap happens, within a few requests of the start. Split reads and split writes that straddle word 23 and word 0 are therefore checked against a reference byte array. The same build checks back-to-back hand-offs in the final cycle of every kind of sequence.

// File: rtl/ums_pkg.sv
package ums_pkg;

   typedef enum logic [2:0] {
      OP_RD_WORD  = 3'd0,
      OP_WR_WORD  = 3'd1,
      OP_RD_BYTE  = 3'd2,
      OP_WR_BYTE  = 3'd3,
      OP_RD_SPLIT = 3'd4,
      OP_WR_SPLIT = 3'd5
   } op_e;

   typedef struct packed {
      logic trouble;   // lane network cannot serve the access alone
      logic lo_src;    // result low lane takes memory lane 1 when set
      logic hi_zero;   // result high lane forced to zero when set
   } steer_t;

   // Steering function: access kind (word when set) and byte-select bit.
   function automatic steer_t steer_of(input logic is_word, input logic bsel);
      steer_t s;
      s.trouble = is_word & bsel;
      s.lo_src  = ~is_word & bsel;
      s.hi_zero = ~is_word;
      return s;
   endfunction

   function automatic op_e classify(input logic wr, input logic is_word,
                                    input logic trouble);
      op_e o;
      if (is_word) begin
         if (trouble) o = wr ? OP_WR_SPLIT : OP_RD_SPLIT;
         else         o = wr ? OP_WR_WORD  : OP_RD_WORD;
      end else begin
         o = wr ? OP_WR_BYTE : OP_RD_BYTE;
      end
      return o;
   endfunction

   function automatic logic [1:0] final_step(input op_e o);
      logic [1:0] s;
      case (o)
         OP_WR_BYTE, OP_RD_SPLIT: s = 2'd1;
         OP_WR_SPLIT:             s = 2'd3;
         default:                 s = 2'd0;
      endcase
      return s;
   endfunction

   function automatic logic is_rmw(input op_e o);
      return (o == OP_WR_BYTE) || (o == OP_WR_SPLIT);
   endfunction

endpackage

// File: rtl/ums_lane_net.sv
module ums_lane_net #(
   parameter int BW = 8
) (
   input  logic [2*BW-1:0] rd_word,
   input  logic            lo_src,
   input  logic            hi_zero,
   input  logic [BW-1:0]   ins_byte,
   input  logic            ins_lane,
   output logic [2*BW-1:0] steered,
   output logic [2*BW-1:0] merged,
   output logic [BW-1:0]   lane_lo,
   output logic [BW-1:0]   lane_hi
);
   localparam int LANES = 2;

   logic [BW-1:0] lane [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = rd_word[g*BW +: BW];
      assign merged[g*BW +: BW] = (ins_lane == 1'(g)) ? ins_byte : lane[g];
   end

   assign lane_lo = lane[0];
   assign lane_hi = lane[1];
   assign steered = {(hi_zero ? {BW{1'b0}} : lane[1]), lane[lo_src]};

endmodule

// File: rtl/ums_wrap_inc.sv
module ums_wrap_inc #(
   parameter int WA_W      = 7,
   parameter int MEM_WORDS = 128
) (
   input  logic [WA_W-1:0] cur,
   output logic [WA_W-1:0] nxt
);
   localparam int SPAN = 1 << WA_W;

   if (MEM_WORDS == SPAN) begin : g_rollover
      assign nxt = cur + 1'b1;
   end else begin : g_compare
      localparam logic [WA_W-1:0] TOP = WA_W'(MEM_WORDS - 1);
      assign nxt = (cur == TOP) ? '0 : cur + 1'b1;
   end

endmodule

// File: rtl/ums_seq_ctrl.sv
module ums_seq_ctrl
   import ums_pkg::*;
#(
   parameter int BW   = 8,
   parameter int WA_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic            req_word,
   input  logic [WA_W:0]   req_addr,
   input  logic [2*BW-1:0] req_wdata,
   output logic            rsp_done,
   output logic [2*BW-1:0] rsp_rdata,
   output logic [WA_W-1:0] mem_addr,
   output logic            mem_we,
   output logic [2*BW-1:0] mem_wdata,
   input  logic [WA_W-1:0] wa_next,
   output logic [WA_W-1:0] wa_cur,
   output logic            net_lo_src,
   output logic            net_hi_zero,
   output logic [BW-1:0]   net_ins_byte,
   output logic            net_ins_lane,
   input  logic [2*BW-1:0] net_steered,
   input  logic [2*BW-1:0] net_merged,
   input  logic [BW-1:0]   net_lane_lo,
   input  logic [BW-1:0]   net_lane_hi,
   output logic            busy,
   output op_e             op_cur
);
   localparam int DW = 2 * BW;

   logic            busy_q;
   logic [1:0]      step_q;
   op_e             op_q;
   logic [WA_W-1:0] wa_q;
   logic            bsel_q;
   logic            lo_src_q;
   logic            hi_zero_q;
   logic [DW-1:0]   wdata_q;
   logic [DW-1:0]   mbuf_q;
   logic [DW-1:0]   rdata_q;
   logic [BW-1:0]   acc_lo_q;
   logic            done_q;

   steer_t          in_steer;
   op_e             in_op;
   logic            last;
   logic            accept;
   logic            use_next;
   logic            rmw_rd;
   logic [DW-1:0]   rd_final;

   always_comb begin
      in_steer = steer_of(req_word, req_addr[0]);
      in_op    = classify(req_write, req_word, in_steer.trouble);
      last     = busy_q && (step_q == final_step(op_q));
      accept   = req_valid && req_ready;
      use_next = ((op_q == OP_RD_SPLIT) && (step_q == 2'd1)) ||
                 ((op_q == OP_WR_SPLIT) && step_q[1]);
      rmw_rd   = busy_q && is_rmw(op_q) && !step_q[0];
   end

   // lane insert control for read-modify-write
   always_comb begin
      if (op_q == OP_WR_SPLIT) begin
         net_ins_byte = step_q[1] ? wdata_q[DW-1:BW] : wdata_q[BW-1:0];
         net_ins_lane = ~step_q[1];
      end else begin
         net_ins_byte = wdata_q[BW-1:0];
         net_ins_lane = bsel_q;
      end
   end

   always_comb begin
      case (op_q)
         OP_RD_SPLIT:            rd_final = {net_lane_lo, acc_lo_q};
         OP_RD_WORD, OP_RD_BYTE: rd_final = net_steered;
         default:                rd_final = '0;
      endcase
   end

   assign req_ready   = !busy_q || last;
   assign mem_addr    = use_next ? wa_next : wa_q;
   assign mem_we      = busy_q && ((op_q == OP_WR_WORD) ||
                                   (is_rmw(op_q) && step_q[0]));
   assign mem_wdata   = (op_q == OP_WR_WORD) ? wdata_q : mbuf_q;
   assign wa_cur      = wa_q;
   assign net_lo_src  = lo_src_q;
   assign net_hi_zero = hi_zero_q;
   assign rsp_done    = done_q;
   assign rsp_rdata   = rdata_q;
   assign busy        = busy_q;
   assign op_cur      = op_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         step_q    <= 2'd0;
         op_q      <= OP_RD_WORD;
         wa_q      <= '0;
         bsel_q    <= 1'b0;
         lo_src_q  <= 1'b0;
         hi_zero_q <= 1'b0;
         wdata_q   <= '0;
         mbuf_q    <= '0;
         rdata_q   <= '0;
         acc_lo_q  <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= last;
         if (last) rdata_q <= rd_final;
         if (rmw_rd) mbuf_q <= net_merged;
         if (busy_q && (op_q == OP_RD_SPLIT) && (step_q == 2'd0))
            acc_lo_q <= net_lane_hi;
         if (accept) begin
            busy_q    <= 1'b1;
            step_q    <= 2'd0;
            op_q      <= in_op;
            wa_q      <= req_addr[WA_W:1];
            bsel_q    <= req_addr[0];
            lo_src_q  <= in_steer.lo_src;
            hi_zero_q <= in_steer.hi_zero;
            wdata_q   <= req_wdata;
         end else if (last) begin
            busy_q <= 1'b0;
            step_q <= 2'd0;
         end else if (busy_q) begin
            step_q <= step_q + 2'd1;
         end
      end
   end

endmodule

// File: rtl/ums_seq.sv
module ums_seq
   import ums_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int MEM_WORDS = 2 ** (ADDR_W - 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic                  req_word,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [2*BYTE_W-1:0]   req_wdata,
   output logic                  rsp_done,
   output logic [2*BYTE_W-1:0]   rsp_rdata,
   output logic [ADDR_W-2:0]     mem_addr,
   output logic                  mem_we,
   output logic [2*BYTE_W-1:0]   mem_wdata,
   input  logic [2*BYTE_W-1:0]   mem_rdata
);
   localparam int DW   = 2 * BYTE_W;
   localparam int WA_W = ADDR_W - 1;

   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if ((MEM_WORDS < 2) || (MEM_WORDS > (1 << WA_W))) begin : g_bad_depth
      $error("MEM_WORDS must lie in 2 .. 2**(ADDR_W-1)");
   end

   logic [WA_W-1:0] wa_cur;
   logic [WA_W-1:0] wa_next;
   logic            net_lo_src;
   logic            net_hi_zero;
   logic [BYTE_W-1:0] net_ins_byte;
   logic            net_ins_lane;
   logic [DW-1:0]   net_steered;
   logic [DW-1:0]   net_merged;
   logic [BYTE_W-1:0] net_lane_lo;
   logic [BYTE_W-1:0] net_lane_hi;
   logic            ctl_busy;
   op_e             ctl_op;

   ums_wrap_inc #(
      .WA_W      (WA_W),
      .MEM_WORDS (MEM_WORDS)
   ) u_wrap (
      .cur (wa_cur),
      .nxt (wa_next)
   );

   ums_lane_net #(
      .BW (BYTE_W)
   ) u_net (
      .rd_word  (mem_rdata),
      .lo_src   (net_lo_src),
      .hi_zero  (net_hi_zero),
      .ins_byte (net_ins_byte),
      .ins_lane (net_ins_lane),
      .steered  (net_steered),
      .merged   (net_merged),
      .lane_lo  (net_lane_lo),
      .lane_hi  (net_lane_hi)
   );

   ums_seq_ctrl #(
      .BW   (BYTE_W),
      .WA_W (WA_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_write    (req_write),
      .req_word     (req_word),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .rsp_done     (rsp_done),
      .rsp_rdata    (rsp_rdata),
      .mem_addr     (mem_addr),
      .mem_we       (mem_we),
      .mem_wdata    (mem_wdata),
      .wa_next      (wa_next),
      .wa_cur       (wa_cur),
      .net_lo_src   (net_lo_src),
      .net_hi_zero  (net_hi_zero),
      .net_ins_byte (net_ins_byte),
      .net_ins_lane (net_ins_lane),
      .net_steered  (net_steered),
      .net_merged   (net_merged),
      .net_lane_lo  (net_lane_lo),
      .net_lane_hi  (net_lane_hi),
      .busy         (ctl_busy),
      .op_cur       (ctl_op)
   );

endmodule

// File: rtl/ums_seq_chk.sv
module ums_seq_chk
   import ums_pkg::*;
#(
   parameter int WA_W = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            rsp_done,
   input logic            mem_we,
   input logic [WA_W-1:0] mem_addr,
   input logic            busy,
   input op_e             op
);

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req_ready && !rsp_done && !mem_we));

   assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);

   assert_midseq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !req_ready) |=> busy);

   assert_done_after_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> ($past(busy) && $past(req_ready)));

   assert_we_in_seq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   assert_writeback_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && is_rmw(op)) |-> (!$past(mem_we) && (mem_addr == $past(mem_addr))));

endmodule

bind ums_seq ums_seq_chk #(
   .WA_W (WA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_done  (rsp_done),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .busy      (ctl_busy),
   .op        (ctl_op)
);

// File: tb/ums_seq_tb_top.sv
module ums_seq_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int BW  = 8;
   localparam int AW  = 6;
   localparam int NW  = 24;
   localparam int DW  = 2 * BW;
   localparam int WAW = AW - 1;
   localparam int WD_LIMIT = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic           req_valid = 1'b0;
   logic           req_write = 1'b0;
   logic           req_word  = 1'b0;
   logic [AW-1:0]  req_addr  = '0;
   logic [DW-1:0]  req_wdata = '0;
   logic           req_ready;
   logic           rsp_done;
   logic [DW-1:0]  rsp_rdata;
   logic [WAW-1:0] mem_addr;
   logic           mem_we;
   logic [DW-1:0]  mem_wdata;
   logic [DW-1:0]  mem_rdata;

   ums_seq #(
      .BYTE_W    (BW),
      .ADDR_W    (AW),
      .MEM_WORDS (NW)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_word  (req_word),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_done  (rsp_done),
      .rsp_rdata (rsp_rdata),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   // memory model: same-cycle read, write on the edge
   logic [DW-1:0] mem     [NW];
   logic [DW-1:0] ref_mem [NW];

   assign mem_rdata = (int'(mem_addr) < NW) ? mem[mem_addr] : '0;
   always @(posedge clk) if (mem_we && (int'(mem_addr) < NW)) mem[mem_addr] <= mem_wdata;

   int cyc = 0;
   int we_cnt = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && mem_we) we_cnt <= we_cnt + 1;
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   typedef struct {
      int            start;
      int            lat;
      bit            rd;
      logic [DW-1:0] data;
      int            we_tot;
      string         tag;
   } exp_t;

   exp_t sb[$];
   int   we_exp = 0;

   function automatic logic [BW-1:0] rbyte(input int ba);
      int w = (ba / 2) % NW;
      return (ba % 2) ? ref_mem[w][DW-1:BW] : ref_mem[w][BW-1:0];
   endfunction

   task automatic wbyte(input int ba, input logic [BW-1:0] b);
      int w = (ba / 2) % NW;
      if (ba % 2) ref_mem[w][DW-1:BW] = b;
      else        ref_mem[w][BW-1:0]  = b;
   endtask

   // driver: predicts the result, pushes it, then performs the handshake
   task automatic issue(input bit wr, input bit word, input int ba,
                        input logic [DW-1:0] d, input string tag);
      exp_t e;
      int n;
      e.tag  = tag;
      e.rd   = !wr;
      e.data = '0;
      if (word) n = wr ? ((ba % 2) ? 4 : 1) : ((ba % 2) ? 2 : 1);
      else      n = wr ? 2 : 1;
      if (!wr) begin
         e.data = word ? {rbyte(ba + 1), rbyte(ba)} : {{BW{1'b0}}, rbyte(ba)};
      end else if (word) begin
         wbyte(ba, d[BW-1:0]);
         wbyte(ba + 1, d[DW-1:BW]);
         we_exp += (ba % 2) ? 2 : 1;
      end else begin
         wbyte(ba, d[BW-1:0]);
         we_exp += 1;
      end
      e.we_tot = we_exp;
      e.lat    = n + 1;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_word  = word;
      req_addr  = AW'(ba);
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      e.start = cyc;
      sb.push_back(e);
      @(posedge clk);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops the scoreboard on each completion pulse
   exp_t got;
   always @(negedge clk) begin
      if (rst_n && rsp_done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R10", "done with nothing pending", 1, 0);
         end else begin
            got = sb.pop_front();
            check((cyc - got.start) == got.lat, got.tag, "cycles to done",
                  cyc - got.start, got.lat);
            if (got.rd)
               check(rsp_rdata == got.data, got.tag, "read data",
                     longint'(rsp_rdata), longint'(got.data));
            check(we_cnt == got.we_tot, "R11", "write cycle count",
                  we_cnt, got.we_tot);
         end
      end
   end

   task automatic run_all();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(req_ready === 1'b1, "R1", "ready in reset", longint'(req_ready), 1);
      check(rsp_done === 1'b0, "R1", "done in reset", longint'(rsp_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready === 1'b1, "R1", "ready after reset", longint'(req_ready), 1);
      check(mem_we === 1'b0, "R1", "write enable after reset", longint'(mem_we), 0);
      check(rsp_done === 1'b0, "R1", "done after reset", longint'(rsp_done), 0);

      issue(0, 1, 4,  '0, "R2");
      issue(0, 1, 46, '0, "R2");
      issue(0, 0, 6,  '0, "R4");
      issue(0, 0, 7,  '0, "R4");
      issue(0, 1, 9,  '0, "R6");
      issue(0, 1, 47, '0, "R8");
      issue(1, 1, 10, 16'hBEEF, "R3");
      issue(0, 1, 10, '0, "R3");
      issue(1, 0, 13, 16'h005A, "R5");
      issue(1, 0, 12, 16'h0011, "R5");
      issue(0, 1, 12, '0, "R5");
      issue(1, 1, 15, 16'hC0DE, "R7");
      issue(0, 1, 14, '0, "R7");
      issue(0, 1, 16, '0, "R7");
      issue(0, 1, 15, '0, "R7");
      issue(1, 1, 47, 16'h7E81, "R8");
      issue(0, 1, 46, '0, "R8");
      issue(0, 1, 0,  '0, "R8");
      issue(0, 1, 47, '0, "R8");
      idle(6);

      // ready stays low until the last of four cycles (R9)
      issue(1, 1, 21, 16'h3C96, "R9");
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R9", "ready in cycle 1 of 4", longint'(req_ready), 0);
      @(negedge clk);
      check(req_ready == 1'b0, "R9", "ready in cycle 2 of 4", longint'(req_ready), 0);
      @(negedge clk);
      check(req_ready == 1'b0, "R9", "ready in cycle 3 of 4", longint'(req_ready), 0);
      @(negedge clk);
      check(req_ready == 1'b1, "R9", "ready in cycle 4 of 4", longint'(req_ready), 1);
      idle(4);

      // back-to-back mix, handed over in each final cycle (R10)
      issue(0, 0, 21, '0, "R10");
      issue(0, 0, 22, '0, "R10");
      issue(1, 0, 3,  16'h00A5, "R10");
      issue(1, 1, 5,  16'h1234, "R10");
      issue(0, 1, 3,  '0, "R10");
      issue(0, 1, 2,  '0, "R10");
      issue(0, 1, 6,  '0, "R10");
      idle(10);

      for (int i = 0; i < NW; i++)
         check(mem[i] == ref_mem[i], "R5", $sformatf("memory word %0d", i),
               longint'(mem[i]), longint'(ref_mem[i]));
      check(sb.size() == 0, "R10", "responses still pending", sb.size(), 0);
   endtask

   initial begin
      for (int i = 0; i < NW; i++) begin
         mem[i]     = {8'(8'h41 + 2 * i), 8'(8'h10 + 2 * i)};
         ref_mem[i] = mem[i];
      end
      fork
         begin
            run_all();
         end
         begin
            repeat (WD_LIMIT) @(posedge clk);
            check(1'b0, "R10", "watchdog expired", cyc, WD_LIMIT);
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule